// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block turns a 6-bit operand specifier into the effective address of that operand. It works against a file of eight 16-bit general registers, where register 6 acts as the stack pointer and register 7 as the program counter. It uses a combinational read port into that file and a write port for the automatic step updates. When the operand needs an index word or an indirect pointer, it fetches it through a request/acknowledge memory read port.

An instruction decoder raises `start` for one cycle with a source specifier, a destination specifier, a flag saying whether the source is present, and a byte/word flag. The sequencer evaluates the source first and then the destination. For each operand it pulses `ea_valid` once and gives one of two results. Either the operand sits in register `ea_reg` (`ea_is_reg` high), or the operand lives at memory address `ea_addr`. `ea_is_dst` marks which operand the pulse belongs to. Immediate, absolute and relative operands need no special handling: they fall out of the ordinary modes applied to register 7.

Top module: `operand_ea_seq`

## Requirements
- R1: Specifier bits 5:3 select the mode and bits 2:0 the register. Mode 0 reports `ea_is_reg`=1 with `ea_reg` equal to the register field, writes no register and makes no memory read.
- R2: Mode 1 reports the register's current value as the address and leaves the register unchanged.
- R3: Modes 2 (step-after) and 3 (step-after, indirect) use the register's old value as the location and then add the step to the register.
- R4: Modes 4 (step-before) and 5 (step-before, indirect) subtract the step from the register and use the new value as the location.
- R5: The step is 1 when `byte_op`=1 and 2 otherwise. Registers 6 and 7 always step by 2.
- R6: Modes 6 and 7 read the word at the address held in register 7 and then add 2 to register 7. The location is that word plus the register's value, and for register 7 the value after the increment is used.
- R7: Modes 3, 5 and 7 read one more word at the computed location, and that word becomes `ea_addr`.
- R8: With `has_src`=1 the source result (`ea_is_dst`=0) comes out before the destination result (`ea_is_dst`=1). With `has_src`=0 only the destination is produced.
- R9: The step update of modes 2 to 5 is written in the cycle the specifier is evaluated, before any memory read of that operand completes, however long the read stalls.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_ack`.
- R11: `ea_valid` is a one-cycle pulse. With zero memory wait, an operand's result appears 2 cycles after its evaluation starts, plus 1 cycle for an indirect read and 2 cycles for an index word. Each memory read adds one cycle for every wait cycle before `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (taken when idle) |
| has_src | input | 1 | Source specifier present |
| src_spec | input | 6 | Source specifier |
| dst_spec | input | 6 | Destination specifier |
| byte_op | input | 1 | Byte operation flag |
| rf_raddr | output | 3 | Register read address |
| rf_rdata | input | 16 | Register read data (combinational) |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 3 | Register write address |
| rf_wdata | output | 16 | Register write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 16 | Memory read data |
| busy | output | 1 | Sequence in progress |
| ea_valid | output | 1 | Result pulse |
| ea_is_reg | output | 1 | Operand is in a register |
| ea_reg | output | 3 | Register of a register operand |
| ea_addr | output | 16 | Effective address |
| ea_is_dst | output | 1 | Result belongs to the destination |

## Verification
The start pulse is taken at one clock edge. For a register operand, or a direct one, `ea_valid` rises one edge later. An indirect read adds 1 + wait cycles, and an index word adds 2 + wait cycles. A destination result follows its source result by the same per-operand count. The bench counts clock edges from the start edge, or from the previous result, and compares that count with the expected latency. It samples every result and the register model on the falling edge in the cycle `ea_valid` is high. The write-before-stall behaviour is checked in the middle of a held memory request.

// File: rtl/operand_ea_seq.sv
module operand_ea_seq #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          has_src,
  input  logic [5:0]    src_spec,
  input  logic [5:0]    dst_spec,
  input  logic          byte_op,
  output logic [2:0]    rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [2:0]    rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          ea_valid,
  output logic          ea_is_reg,
  output logic [2:0]    ea_reg,
  output logic [DW-1:0] ea_addr,
  output logic          ea_is_dst
);
  localparam logic [2:0]    PC_REG = 3'd7;
  localparam logic [DW-1:0] WSTEP  = DW'(2);
  localparam logic [DW-1:0] BSTEP  = DW'(1);

  typedef enum logic [2:0] {ST_IDLE, ST_EVAL, ST_IDX, ST_IADD, ST_PTR, ST_OUT} st_t;

  st_t           state;
  logic [5:0]    spec_s, spec_d;
  logic          on_dst, byte_q, isreg_q;
  logic [DW-1:0] idx_q, ptr_q, addr_q;

  wire [5:0]    cur  = on_dst ? spec_d : spec_s;
  wire [2:0]    mode = cur[5:3];
  wire [2:0]    rn   = cur[2:0];
  wire [DW-1:0] step = (byte_q && rn[2:1] != 2'b11) ? BSTEP : WSTEP;
  wire [DW-1:0] dec  = rf_rdata - step;

  assign rf_raddr  = (state == ST_IDX) ? PC_REG : rn;
  assign mem_req   = (state == ST_IDX) || (state == ST_PTR);
  assign mem_addr  = (state == ST_IDX) ? rf_rdata : ptr_q;
  assign busy      = (state != ST_IDLE);
  assign ea_valid  = (state == ST_OUT);
  assign ea_is_reg = isreg_q;
  assign ea_reg    = rn;
  assign ea_addr   = addr_q;
  assign ea_is_dst = on_dst;

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = rn;
    rf_wdata = rf_rdata + step;
    if (state == ST_EVAL) begin
      rf_we = (mode >= 3'd2) && (mode <= 3'd5);
      if (mode[2]) rf_wdata = dec;
    end else if (state == ST_IDX) begin
      rf_we    = mem_ack;
      rf_waddr = PC_REG;
      rf_wdata = rf_rdata + WSTEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      spec_s  <= '0;
      spec_d  <= '0;
      on_dst  <= 1'b0;
      byte_q  <= 1'b0;
      isreg_q <= 1'b0;
      idx_q   <= '0;
      ptr_q   <= '0;
      addr_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          spec_s <= src_spec;
          spec_d <= dst_spec;
          byte_q <= byte_op;
          on_dst <= !has_src;
          state  <= ST_EVAL;
        end
        ST_EVAL: begin
          isreg_q <= (mode == 3'd0);
          case (mode)
            3'd0:       state <= ST_OUT;
            3'd1, 3'd2: begin addr_q <= rf_rdata; state <= ST_OUT; end
            3'd3:       begin ptr_q  <= rf_rdata; state <= ST_PTR; end
            3'd4:       begin addr_q <= dec;      state <= ST_OUT; end
            3'd5:       begin ptr_q  <= dec;      state <= ST_PTR; end
            default:    state <= ST_IDX;
          endcase
        end
        ST_IDX: if (mem_ack) begin
          idx_q <= mem_rdata;
          state <= ST_IADD;
        end
        ST_IADD: begin
          if (mode[0]) begin
            ptr_q <= rf_rdata + idx_q;
            state <= ST_PTR;
          end else begin
            addr_q <= rf_rdata + idx_q;
            state  <= ST_OUT;
          end
        end
        ST_PTR: if (mem_ack) begin
          addr_q <= mem_rdata;
          state  <= ST_OUT;
        end
        default: begin
          if (!on_dst) begin
            on_dst <= 1'b1;
            state  <= ST_EVAL;
          end else begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/operand_ea_seq_chk.sv
module operand_ea_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          ea_valid,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [DW-1:0] mem_addr,
  input logic          rf_we,
  input logic [2:0]    rf_waddr,
  input logic [2:0]    rf_raddr,
  input logic [DW-1:0] rf_wdata,
  input logic [DW-1:0] rf_rdata
);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |=> !ea_valid);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !rf_we && !ea_valid);

  a_r9_write_same_reg: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_raddr == rf_waddr);

  a_r5_sp_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && rf_waddr[2:1] == 2'b11 |->
      (rf_wdata == rf_rdata + DW'(2)) || (rf_wdata == rf_rdata - DW'(2)));
endmodule

bind operand_ea_seq operand_ea_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ea_valid(ea_valid),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_raddr(rf_raddr),
  .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
);

// File: tb/sim_operand_ea_seq.sv
`timescale 1ns/1ps
module sim_operand_ea_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, has_src = 1'b0, byte_op = 1'b0;
  logic [5:0] src_spec = '0, dst_spec = '0;
  logic [2:0] rf_raddr, rf_waddr, ea_reg;
  logic [15:0] rf_rdata, rf_wdata, mem_addr, mem_rdata, ea_addr;
  logic rf_we, mem_req, mem_ack, busy, ea_valid, ea_is_reg, ea_is_dst;

  always #10 clk = ~clk;

  operand_ea_seq u0 (.*);

  logic [15:0] rf [8];
  int lat = 0;
  int wcnt = 0;
  int ecnt = 0;
  int tests = 0, fails = 0;

  assign rf_rdata  = rf[rf_raddr];
  assign mem_ack   = mem_req && (wcnt == lat);
  assign mem_rdata = ~mem_addr;

  always @(posedge clk) begin
    ecnt <= ecnt + 1;
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (!rst_n || !mem_req || mem_ack) wcnt <= 0;
    else wcnt <= wcnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_regs();
    rf[0] = 16'h1000; rf[1] = 16'h1100; rf[2] = 16'h1200; rf[3] = 16'h1301;
    rf[4] = 16'h1400; rf[5] = 16'h1500; rf[6] = 16'h0800; rf[7] = 16'h0200;
  endtask

  task automatic launch(input logic hs, input logic [5:0] s, input logic [5:0] d,
                        input logic b, output int e0);
    @(negedge clk);
    has_src = hs; src_spec = s; dst_spec = d; byte_op = b; start = 1'b1;
    @(posedge clk);
    #1 e0 = ecnt;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid(output int edges_at);
    int n = 0;
    while (!ea_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    edges_at = ecnt;
  endtask

  // spec, byte, is_reg, addr, checked reg, its value after, cycles
  localparam logic [46:0] VEC [14] = '{
    {6'h03, 1'b0, 1'b1, 16'h0000, 3'd3, 16'h1301, 4'd2},
    {6'h09, 1'b0, 1'b0, 16'h1100, 3'd1, 16'h1100, 4'd2},
    {6'h12, 1'b0, 1'b0, 16'h1200, 3'd2, 16'h1202, 4'd2},
    {6'h12, 1'b1, 1'b0, 16'h1200, 3'd2, 16'h1201, 4'd2},
    {6'h16, 1'b1, 1'b0, 16'h0800, 3'd6, 16'h0802, 4'd2},
    {6'h17, 1'b1, 1'b0, 16'h0200, 3'd7, 16'h0202, 4'd2},
    {6'h24, 1'b1, 1'b0, 16'h13FF, 3'd4, 16'h13FF, 4'd2},
    {6'h26, 1'b1, 1'b0, 16'h07FE, 3'd6, 16'h07FE, 4'd2},
    {6'h18, 1'b0, 1'b0, 16'hEFFF, 3'd0, 16'h1002, 4'd3},
    {6'h2D, 1'b0, 1'b0, 16'hEB01, 3'd5, 16'h14FE, 4'd3},
    {6'h31, 1'b0, 1'b0, 16'h0EFF, 3'd7, 16'h0202, 4'd4},
    {6'h37, 1'b0, 1'b0, 16'h0001, 3'd7, 16'h0202, 4'd4},
    {6'h3A, 1'b0, 1'b0, 16'hF000, 3'd2, 16'h1200, 4'd5},
    {6'h1F, 1'b0, 1'b0, 16'hFDFF, 3'd7, 16'h0202, 4'd3}
  };

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3,R5";
      3'd3: return "R3,R7";
      3'd4: return "R4,R5";
      3'd5: return "R4,R7";
      default: return "R6,R7";
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int e0, e1, e2;
    load_regs();
    repeat (3) @(negedge clk);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset valid", ea_valid, 0);
    chk("R10 reset mem_req", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle rf_we", rf_we, 0);

    for (int i = 0; i < 14; i++) begin
      logic [46:0] v;
      string t;
      v = VEC[i];
      t = tag_of(v[46:44]);
      load_regs();
      lat = 0;
      launch(1'b0, 6'h00, v[46:41], v[40], e0);
      wait_valid(e1);
      chk({t, " is_reg"}, ea_is_reg, v[39]);
      if (v[39]) chk("R1 ea_reg", ea_reg, v[46:41] & 6'h07);
      else chk({t, " ea_addr"}, ea_addr, v[38:23]);
      chk("R8 is_dst", ea_is_dst, 1);
      chk({t, " reg after"}, rf[v[22:20]], v[19:4]);
      chk("R11 latency", e1 - e0 + 1, v[3:0]);
      @(negedge clk);
      chk("R11 pulse", ea_valid, 0);
    end

    // R8: source then destination on the same register
    load_regs(); lat = 0;
    launch(1'b1, 6'h12, 6'h22, 1'b0, e0);
    wait_valid(e1);
    chk("R8 src first", ea_is_dst, 0);
    chk("R8 src addr", ea_addr, 16'h1200);
    @(negedge clk);
    wait_valid(e2);
    chk("R8 dst second", ea_is_dst, 1);
    chk("R8 dst addr", ea_addr, 16'h1200);
    chk("R8 reg final", rf[2], 16'h1200);
    chk("R11 dst gap", e2 - e1, 2);

    // R6 and R8: immediate source then relative destination through register 7
    load_regs(); lat = 0;
    launch(1'b1, 6'h17, 6'h37, 1'b0, e0);
    wait_valid(e1);
    chk("R6 immediate addr", ea_addr, 16'h0200);
    @(negedge clk);
    wait_valid(e2);
    chk("R6 relative addr", ea_addr, 16'h0001);
    chk("R6 pc final", rf[7], 16'h0204);
    chk("R11 index gap", e2 - e1, 4);

    // R9: step written while the pointer read is still stalled
    load_regs(); lat = 3;
    launch(1'b0, 6'h00, 6'h18, 1'b0, e0);
    @(negedge clk);
    chk("R9 req pending", mem_req & ~mem_ack, 1);
    chk("R9 reg stepped", rf[0], 16'h1002);
    wait_valid(e1);
    chk("R7 stalled addr", ea_addr, 16'hEFFF);
    chk("R11 stalled latency", e1 - e0 + 1, 6);

    // R7 and R11: index with indirection, both reads stalled
    load_regs(); lat = 3;
    launch(1'b0, 6'h00, 6'h39, 1'b0, e0);
    wait_valid(e1);
    chk("R7 index deferred addr", ea_addr, 16'hF100);
    chk("R6 pc stepped", rf[7], 16'h0202);
    chk("R11 two stalls", e1 - e0 + 1, 11);

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule